// File: doc/BRIEF.md
# Diskette Controller Command and Status Register

This block sits between a host bus and a diskette controller core. The host sees two word registers. The first is a control/status word, and the second is a data buffer word. A write to the control word can do two things. It can start an initialize, or it can launch one of eight functions with a one-cycle command strobe. The strobe carries the function code and, for the functions that touch a drive, the selected unit. The same write also sets or clears the interrupt enable.

The core reports progress back through single-cycle pulses:

- a transfer-request pulse, meaning the data buffer needs service;
- a completion pulse, optionally qualified as an error;
- a byte load into the data buffer.

The host reads the error, transfer-request, done and interrupt-enable flags from the control word. The interrupt request is the done flag gated by the enable.

After reset every flag is clear, and the block then issues one initialize strobe by itself. The core answers that strobe with a completion pulse, exactly as it does for a host-requested initialize.

Top module: `dsk_csr`

## Requirements
- R1: While reset is held, the control word reads 0x0000 and irq is 0. On the first clock edge after reset is released, initStrobe pulses high for exactly one cycle.
- R2: A control write with bit 14 set does the following:
  - pulses initStrobe;
  - clears done, error and transfer request;
  - issues no cmdStrobe, whatever else is written;
  - leaves the interrupt enable unchanged.
- R3: A control write with bit 0 (execute) set, while done is 1, pulses cmdStrobe for one cycle. It drives cmdFunc with bits 3..1 (0 fill, 1 empty, 2 write sector, 3 read sector, 5 read status, 6 write deleted-data sector, 7 read error register). It clears done and error.
- R4: A control write with execute set while done is 0 is ignored entirely. No strobe is issued and the interrupt enable keeps its value.
- R5: Function code 4 with execute set issues no strobe and leaves done unchanged. Bit 6 of that write still updates the interrupt enable.
- R6: The unit select is taken from bits 9..8.
  - It appears on cmdUnit for the drive functions 2, 3, 5 and 6.
  - For functions 0, 1 and 7, cmdUnit is 0.
- R7: Three flags are read-only and are read back at fixed positions: done on bit 5, error on bit 15 and transfer request on bit 7.
  - A coreDone pulse sets done.
  - If coreErr is high together with coreDone, error is set as well.
  - Host writes to bits 15, 7 and 5 have no effect.
- R8: irq equals done AND interrupt enable (bit 6). Setting the enable while done is already 1 raises irq right after that write.
- R9: A coreTrSet pulse sets transfer request. A host write or read of the data buffer clears it while it is set, and pulses dbTaken for one cycle.
- R10: A host data write is accepted only while transfer request is set. Only bits 7..0 are stored, and the data buffer reads back with bits 15..8 as zero.
- R11: A coreDbLoad pulse places coreDbData in the data buffer, where the host can read it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrCsr | input | 1 | Host write strobe for the control word |
| wrDb | input | 1 | Host write strobe for the data buffer word |
| rdDb | input | 1 | Host read strobe for the data buffer word |
| wrData | input | 16 | Host write data |
| csrRdData | output | 16 | Control word read value |
| dbRdData | output | 16 | Data buffer read value |
| irq | output | 1 | Interrupt request |
| cmdStrobe | output | 1 | One-cycle command launch to the core |
| cmdFunc | output | 3 | Function code qualified by cmdStrobe |
| cmdUnit | output | 2 | Drive unit qualified by cmdStrobe |
| initStrobe | output | 1 | One-cycle initialize request to the core |
| dbByte | output | 8 | Data buffer byte seen by the core |
| dbTaken | output | 1 | Host has written or read the data buffer |
| coreTrSet | input | 1 | Core requests a data buffer transfer |
| coreDone | input | 1 | Core completion pulse |
| coreErr | input | 1 | Completion ended in error (with coreDone) |
| coreDbLoad | input | 1 | Core loads a byte into the data buffer |
| coreDbData | input | 8 | Byte loaded by the core |

## Verification
Control writes are tried in several forms, and each form separates a different case:

- an execute while idle against one while busy, which tells a launched command from an ignored one;
- function 4 against legal codes, which shows whether the decode screens the unused code;
- an initialize with execute and enable also set, which shows whether initialize truly overrides the other bits.

The unit field is sent with drive and non-drive functions to show that the gating depends on the function. Buffer writes are made with transfer request both set and clear, and carry non-zero upper bytes, which exposes acceptance gating and byte masking. Setting the enable once done is already high separates an interrupt level from an edge.

// File: rtl/dsk_csr_pkg.sv
package dsk_csr_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int FUNC_W = 3;
  localparam int UNIT_W = 2;

  localparam int ERR_BIT  = 15;
  localparam int INIT_BIT = 14;
  localparam int UNIT_LSB = 8;
  localparam int TR_BIT   = 7;
  localparam int IE_BIT   = 6;
  localparam int DONE_BIT = 5;
  localparam int FUNC_LSB = 1;
  localparam int EXEC_BIT = 0;

  localparam logic [FUNC_W-1:0] FUNC_UNUSED = 3'd4;

  typedef struct packed {
    logic initGo;
    logic cmdGo;
    logic ieWr;
    logic ieVal;
    logic dbHostWr;
    logic dbHostRd;
  } csrStrobes_t;

  function automatic logic isDriveFunc(input logic [FUNC_W-1:0] f);
    return (f == 3'd2) || (f == 3'd3) || (f == 3'd5) || (f == 3'd6);
  endfunction
endpackage

// File: rtl/dsk_csr_ctrl.sv
module dsk_csr_ctrl
  import dsk_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCsr,
  input  logic              wrDb,
  input  logic              rdDb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              doneFlag,
  input  logic              trFlag,
  output csrStrobes_t       st,
  output logic              cmdStrobe,
  output logic [FUNC_W-1:0] cmdFunc,
  output logic [UNIT_W-1:0] cmdUnit,
  output logic              initStrobe,
  output logic              dbTaken
);
  logic [FUNC_W-1:0] wrFunc;
  logic [UNIT_W-1:0] wrUnit;
  logic              wrInit, wrExec, initPend;
  logic              unusedBits;

  assign wrFunc = wrData[FUNC_LSB +: FUNC_W];
  assign wrUnit = wrData[UNIT_LSB +: UNIT_W];
  assign wrInit = wrData[INIT_BIT];
  assign wrExec = wrData[EXEC_BIT];
  assign unusedBits = ^{wrData[ERR_BIT], wrData[13:10], wrData[TR_BIT],
                        wrData[5:4]};

  always_comb begin
    st          = '0;
    st.initGo   = wrCsr && wrInit;
    st.cmdGo    = wrCsr && !wrInit && wrExec && doneFlag && (wrFunc != FUNC_UNUSED);
    st.ieWr     = wrCsr && !wrInit && !(wrExec && !doneFlag);
    st.ieVal    = wrData[IE_BIT];
    st.dbHostWr = wrDb && trFlag;
    st.dbHostRd = rdDb && trFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initPend   <= 1'b1;
      initStrobe <= 1'b0;
      cmdStrobe  <= 1'b0;
      cmdFunc    <= '0;
      cmdUnit    <= '0;
      dbTaken    <= 1'b0;
    end else begin
      initPend   <= 1'b0;
      initStrobe <= initPend || st.initGo;
      cmdStrobe  <= st.cmdGo;
      dbTaken    <= st.dbHostWr || st.dbHostRd;
      if (st.cmdGo) begin
        cmdFunc <= wrFunc;
        cmdUnit <= isDriveFunc(wrFunc) ? wrUnit : '0;
      end
    end
  end

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);
  p_init_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(initStrobe && cmdStrobe));
  p_no_unused_func_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> (cmdFunc != FUNC_UNUSED));
  p_unit_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && !isDriveFunc(cmdFunc)) |-> (cmdUnit == '0));
endmodule

// File: rtl/dsk_csr_dp.sv
module dsk_csr_dp
  import dsk_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobes_t       st,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              coreTrSet,
  input  logic              coreDone,
  input  logic              coreErr,
  input  logic              coreDbLoad,
  input  logic [BYTE_W-1:0] coreDbData,
  output logic              doneFlag,
  output logic              errFlag,
  output logic              trFlag,
  output logic              ieFlag,
  output logic [BYTE_W-1:0] dbReg
);
  logic flagClr;
  assign flagClr = st.initGo || st.cmdGo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      trFlag   <= 1'b0;
      ieFlag   <= 1'b0;
      dbReg    <= '0;
    end else begin
      if (flagClr)       doneFlag <= 1'b0;
      else if (coreDone) doneFlag <= 1'b1;

      if (flagClr)                   errFlag <= 1'b0;
      else if (coreDone && coreErr)  errFlag <= 1'b1;

      if (flagClr)                             trFlag <= 1'b0;
      else if (coreTrSet)                      trFlag <= 1'b1;
      else if (st.dbHostWr || st.dbHostRd)     trFlag <= 1'b0;

      if (st.ieWr) ieFlag <= st.ieVal;

      if (st.dbHostWr)       dbReg <= wrByte;
      else if (coreDbLoad)   dbReg <= coreDbData;
    end
  end

  p_launch_clears_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.cmdGo |=> (!doneFlag && !errFlag));
  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.initGo |=> (!doneFlag && !trFlag && $stable(ieFlag)));
  p_tr_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (trFlag && st.dbHostWr && !coreTrSet && !flagClr) |=> !trFlag);
  p_done_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (coreDone && !flagClr) |=> doneFlag);
endmodule

// File: rtl/dsk_csr.sv
module dsk_csr
  import dsk_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCsr,
  input  logic              wrDb,
  input  logic              rdDb,
  input  logic [15:0]       wrData,
  output logic [15:0]       csrRdData,
  output logic [15:0]       dbRdData,
  output logic              irq,
  output logic              cmdStrobe,
  output logic [2:0]        cmdFunc,
  output logic [1:0]        cmdUnit,
  output logic              initStrobe,
  output logic [7:0]        dbByte,
  output logic              dbTaken,
  input  logic              coreTrSet,
  input  logic              coreDone,
  input  logic              coreErr,
  input  logic              coreDbLoad,
  input  logic [7:0]        coreDbData
);
  csrStrobes_t       st;
  logic              doneFlag, errFlag, trFlag, ieFlag;
  logic [BYTE_W-1:0] dbReg;

  dsk_csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrCsr(wrCsr), .wrDb(wrDb), .rdDb(rdDb),
    .wrData(wrData), .doneFlag(doneFlag), .trFlag(trFlag), .st(st),
    .cmdStrobe(cmdStrobe), .cmdFunc(cmdFunc), .cmdUnit(cmdUnit),
    .initStrobe(initStrobe), .dbTaken(dbTaken)
  );

  dsk_csr_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrByte(wrData[BYTE_W-1:0]),
    .coreTrSet(coreTrSet), .coreDone(coreDone), .coreErr(coreErr),
    .coreDbLoad(coreDbLoad), .coreDbData(coreDbData),
    .doneFlag(doneFlag), .errFlag(errFlag), .trFlag(trFlag),
    .ieFlag(ieFlag), .dbReg(dbReg)
  );

  always_comb begin
    csrRdData           = '0;
    csrRdData[ERR_BIT]  = errFlag;
    csrRdData[TR_BIT]   = trFlag;
    csrRdData[IE_BIT]   = ieFlag;
    csrRdData[DONE_BIT] = doneFlag;
  end

  assign dbRdData = {{(DATA_W-BYTE_W){1'b0}}, dbReg};
  assign dbByte   = dbReg;
  assign irq      = doneFlag && ieFlag;

  p_irq_on_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && st.ieWr && st.ieVal && !st.cmdGo && !st.initGo && !coreDone) |=> irq);
endmodule

// File: tb/dsk_csr_tb.sv
module dsk_csr_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrCsr, wrDb, rdDb;
  logic [15:0] wrData;
  logic [15:0] csrRdData, dbRdData;
  logic        irq, cmdStrobe, initStrobe, dbTaken;
  logic [2:0]  cmdFunc;
  logic [1:0]  cmdUnit;
  logic [7:0]  dbByte;
  logic        coreTrSet, coreDone, coreErr, coreDbLoad;
  logic [7:0]  coreDbData;

  int nChecks = 0;
  int nErrors = 0;

  always #4 clk = ~clk;

  dsk_csr u_dut (
    .clk(clk), .rstN(rstN), .wrCsr(wrCsr), .wrDb(wrDb), .rdDb(rdDb),
    .wrData(wrData), .csrRdData(csrRdData), .dbRdData(dbRdData), .irq(irq),
    .cmdStrobe(cmdStrobe), .cmdFunc(cmdFunc), .cmdUnit(cmdUnit),
    .initStrobe(initStrobe), .dbByte(dbByte), .dbTaken(dbTaken),
    .coreTrSet(coreTrSet), .coreDone(coreDone), .coreErr(coreErr),
    .coreDbLoad(coreDbLoad), .coreDbData(coreDbData)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [15:0] d);
    @(negedge clk); wrCsr = 1'b1; wrData = d;
    @(negedge clk); wrCsr = 1'b0; wrData = '0;
  endtask

  task automatic dbWrite(input logic [15:0] d);
    @(negedge clk); wrDb = 1'b1; wrData = d;
    @(negedge clk); wrDb = 1'b0; wrData = '0;
  endtask

  task automatic dbRead();
    @(negedge clk); rdDb = 1'b1;
    @(negedge clk); rdDb = 1'b0;
  endtask

  task automatic corePulse(input logic tr, input logic dn, input logic er,
                           input logic ld, input logic [7:0] b);
    @(negedge clk);
    coreTrSet = tr; coreDone = dn; coreErr = er; coreDbLoad = ld; coreDbData = b;
    @(negedge clk);
    coreTrSet = 0; coreDone = 0; coreErr = 0; coreDbLoad = 0; coreDbData = '0;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 csr in reset", csrRdData, 16'h0000);
    chk("R1 irq in reset", {15'b0, irq}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 init pulse", {15'b0, initStrobe}, 16'h0001);
    @(negedge clk);
    chk("R1 init single", {15'b0, initStrobe}, 16'h0000);
    corePulse(0, 1, 0, 0, 8'h00);
    chk("R7 done after coreDone", csrRdData, 16'h0020);
  endtask

  task automatic tEnableIrq();
    csrWrite(16'h80C0);
    chk("R8 irq at once", {15'b0, irq}, 16'h0001);
    chk("R7 ro flags unchanged", csrRdData, 16'h0060);
  endtask

  task automatic tLaunch();
    csrWrite(16'h0200 | 16'h0040 | (16'd3 << 1) | 16'h0001);
    chk("R3 strobe", {15'b0, cmdStrobe}, 16'h0001);
    chk("R3 func", {13'b0, cmdFunc}, 16'h0003);
    chk("R6 drive unit", {14'b0, cmdUnit}, 16'h0002);
    chk("R3 done cleared", csrRdData, 16'h0040);
    chk("R8 irq drops", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    chk("R3 strobe one cycle", {15'b0, cmdStrobe}, 16'h0000);
  endtask

  task automatic tBusy();
    csrWrite(16'h0001);
    chk("R4 no strobe when busy", {15'b0, cmdStrobe}, 16'h0000);
    chk("R4 enable kept", csrRdData, 16'h0040);
  endtask

  task automatic tBuffer();
    corePulse(1, 0, 0, 0, 8'h00);
    chk("R9 tr set", csrRdData, 16'h00C0);
    dbWrite(16'hABCD);
    chk("R10 byte stored", dbRdData, 16'h00CD);
    chk("R10 core byte", {8'b0, dbByte}, 16'h00CD);
    chk("R9 dbTaken", {15'b0, dbTaken}, 16'h0001);
    chk("R9 tr cleared", csrRdData, 16'h0040);
    dbWrite(16'h1111);
    chk("R10 write ignored without tr", dbRdData, 16'h00CD);
    chk("R9 no dbTaken without tr", {15'b0, dbTaken}, 16'h0000);
    corePulse(1, 0, 0, 1, 8'h5A);
    chk("R11 core load", dbRdData, 16'h005A);
    dbRead();
    chk("R9 tr cleared by read", csrRdData, 16'h0040);
  endtask

  task automatic tError();
    corePulse(0, 1, 1, 0, 8'h00);
    chk("R7 error and done", csrRdData, 16'h8060);
    chk("R8 irq on done", {15'b0, irq}, 16'h0001);
  endtask

  task automatic tNonDrive();
    csrWrite(16'h0300 | 16'h0040 | (16'd1 << 1) | 16'h0001);
    chk("R6 func1 strobe", {15'b0, cmdStrobe}, 16'h0001);
    chk("R6 func1 unit zero", {14'b0, cmdUnit}, 16'h0000);
    chk("R3 error cleared", csrRdData, 16'h0040);
    corePulse(0, 1, 0, 0, 8'h00);
    csrWrite(16'h0300 | 16'h0040 | (16'd7 << 1) | 16'h0001);
    chk("R6 func7 unit zero", {13'b0, cmdFunc, cmdUnit} , 16'h001C);
    corePulse(0, 1, 0, 0, 8'h00);
  endtask

  task automatic tUnused();
    csrWrite(16'h0000 | (16'd4 << 1) | 16'h0001);
    chk("R5 no strobe func4", {15'b0, cmdStrobe}, 16'h0000);
    chk("R5 done kept, ie cleared", csrRdData, 16'h0020);
    csrWrite(16'h0040);
  endtask

  task automatic tInit();
    corePulse(1, 0, 0, 0, 8'h00);
    chk("R2 setup", csrRdData, 16'h00E0);
    csrWrite(16'h4000 | (16'd2 << 1) | 16'h0001);
    chk("R2 init strobe", {15'b0, initStrobe}, 16'h0001);
    chk("R2 no cmd strobe", {15'b0, cmdStrobe}, 16'h0000);
    chk("R2 flags cleared ie kept", csrRdData, 16'h0040);
  endtask

  initial begin
    rstN = 0; wrCsr = 0; wrDb = 0; rdDb = 0; wrData = '0;
    coreTrSet = 0; coreDone = 0; coreErr = 0; coreDbLoad = 0; coreDbData = '0;
    tReset();
    tEnableIrq();
    tLaunch();
    tBusy();
    tBuffer();
    tError();
    tNonDrive();
    tUnused();
    tInit();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule